// File: doc/BRIEF.md
# Indirect Statistics Counter Window

This block holds the event counters of a network MAC: 38 counters of 32 bits, one increment strobe each. The first 15 counters count transmit events and the remaining 23 count receive events. Software does not see one address per counter. It sees two registers on a small register bus. The selector register holds a counter index and three option bits. The window register returns or loads whichever counter the selector points at.

Software programs the selector once and then makes repeated window accesses. Each window access can advance the index by one and can clear a counter that has just been read, so a full sweep of the bank needs no extra selector writes. A two-state sequencer controls when these side effects happen. In `ST_IDLE` the block accepts bus cycles. A window access sends it to `ST_COMMIT` for exactly one cycle, and there the pending clear and index advance are applied to the counter and index that the access used. `ST_COMMIT` always returns to `ST_IDLE`. While the block is in `ST_COMMIT`, `bus_ready` is low and no bus cycle is accepted.

A bus cycle is accepted on a rising edge where `bus_valid` and `bus_ready` are both high. The window sits at byte offset 0x164 and the selector at 0x168.

Top module: `stat_cnt_window`

## Requirements
- R1: After reset every counter holds zero, the selector reads as 0x0000_0000 and `bus_ready` is high.
- R2: The selector fields are index in bits [5:0], write mode in bit 8, clear-after-read in bit 9 and auto-advance in bit 10. Bits [31:11] and [7:6] read as zero whatever was written. A selector write or read takes one cycle, leaves `bus_ready` high and does not move the index.
- R3: Each cycle with a strobe high adds one to its counter. A counter at 0xFFFF_FFFF wraps to zero. Transmit strobe k drives counter index k, and receive strobe j drives counter index 15+j.
- R4: A read is answered in the cycle after it is accepted, with `bus_rvalid` high. A window read returns the full 32-bit value of the selected counter. A read of any offset other than the two registers returns zero.
- R5: With write mode set, a window write loads the selected counter with the written word. A strobe for that counter in the same cycle is overridden by the load. With write mode clear, a window write changes no counter.
- R6: With clear-after-read set, a window read returns the value before clearing and the counter reads zero afterwards. A strobe for that counter in the commit cycle leaves it at 1. Window writes never clear.
- R7: With auto-advance set, each window access, read or write, moves the index up by one. The index wraps from 0x25, or from any larger value, back to 0x00.
- R8: While the index is above 0x25, window reads return zero and window writes change no counter.
- R9: After every accepted window access, `bus_ready` is low for exactly one cycle, and a bus cycle offered in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus cycle request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Block can accept a bus cycle |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read answer strobe |
| tx_evt | input | 15 | Transmit event strobes |
| rx_evt | input | 23 | Receive event strobes |

## Verification
The hardest case to reach is a strobe landing exactly in the commit cycle of a clear-after-read. That cycle exists only for one clock after the read is accepted. The bench drives the read, releases `bus_valid` at the next falling edge, raises that counter's strobe in the same step, and then reads the counter back expecting 1. A load that coincides with a strobe is set up the same way, and the bench then sweeps the whole bank with auto-advance against an arithmetic model.

// File: rtl/stat_cnt_pkg.sv
package stat_cnt_pkg;

    localparam int TX_CNT_DEF  = 15;
    localparam int RX_CNT_DEF  = 23;
    localparam int CNT_W_DEF   = 32;
    localparam int ADDR_W_DEF  = 9;
    localparam int IDX_W       = 6;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } acc_state_t;

    typedef struct packed {
        logic             adv;
        logic             clr_rd;
        logic             wr_mode;
        logic [IDX_W-1:0] idx;
    } sel_reg_t;

endpackage

// File: rtl/stat_cnt_seq.sv
module stat_cnt_seq
    import stat_cnt_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DATA_W   = CNT_W_DEF,
    parameter int NUM_CNT  = TX_CNT_DEF + RX_CNT_DEF,
    parameter logic [ADDR_W-1:0] WIN_OFS = 9'h164,
    parameter logic [ADDR_W-1:0] SEL_OFS = 9'h168
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output sel_reg_t          sel_q,
    output logic              load_en,
    output logic              clr_en,
    output logic              in_commit
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CNT - 1);

    acc_state_t state_q, state_d;
    logic       take, win_hit, sel_hit;
    logic       clr_pend_q, adv_pend_q;
    logic       idx_ok;

    assign take    = bus_valid && (state_q == ST_IDLE);
    assign win_hit = take && (bus_addr == WIN_OFS);
    assign sel_hit = take && (bus_addr == SEL_OFS);
    assign idx_ok  = (sel_q.idx <= LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_hit) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        bus_ready = (state_q == ST_IDLE);
        in_commit = (state_q == ST_COMMIT);
        load_en   = win_hit && bus_write && sel_q.wr_mode && idx_ok;
        clr_en    = (state_q == ST_COMMIT) && clr_pend_q && idx_ok;
    end

    // pending side effects of a window access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_pend_q <= 1'b0;
            adv_pend_q <= 1'b0;
        end else begin
            clr_pend_q <= win_hit && !bus_write && sel_q.clr_rd;
            adv_pend_q <= win_hit && sel_q.adv;
        end
    end

    // selector register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_hit && bus_write) begin
            sel_q.adv     <= bus_wdata[10];
            sel_q.clr_rd  <= bus_wdata[9];
            sel_q.wr_mode <= bus_wdata[8];
            sel_q.idx     <= bus_wdata[IDX_W-1:0];
        end else if ((state_q == ST_COMMIT) && adv_pend_q) begin
            sel_q.idx <= (sel_q.idx >= LAST_IDX) ? '0 : sel_q.idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/stat_cnt_bank.sv
module stat_cnt_bank
    import stat_cnt_pkg::*;
#(
    parameter int NUM_CNT = TX_CNT_DEF + RX_CNT_DEF,
    parameter int CNT_W   = CNT_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] evt,
    input  logic [IDX_W-1:0]   sel,
    input  logic               load_en,
    input  logic [CNT_W-1:0]   load_val,
    input  logic               clr_en,
    output logic [CNT_W-1:0]   sel_val
);

    logic [CNT_W-1:0] cnt_q [NUM_CNT];

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        logic hit;
        assign hit = (sel == IDX_W'(gi));
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[gi] <= '0;
            else if (load_en && hit)
                cnt_q[gi] <= load_val;
            else if (clr_en && hit)
                cnt_q[gi] <= evt[gi] ? CNT_W'(1) : '0;
            else if (evt[gi])
                cnt_q[gi] <= cnt_q[gi] + CNT_W'(1);
        end
    end

    always_comb begin
        sel_val = '0;
        for (int i = 0; i < NUM_CNT; i++)
            if (sel == IDX_W'(i)) sel_val = cnt_q[i];
    end

endmodule

// File: rtl/stat_cnt_window.sv
module stat_cnt_window
    import stat_cnt_pkg::*;
#(
    parameter int TX_CNT = TX_CNT_DEF,
    parameter int RX_CNT = RX_CNT_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] WIN_OFS = 9'h164,
    parameter logic [ADDR_W-1:0] SEL_OFS = 9'h168
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic              bus_ready,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic [TX_CNT-1:0] tx_evt,
    input  logic [RX_CNT-1:0] rx_evt
);

    localparam int NUM_CNT = TX_CNT + RX_CNT;
    localparam int PAD_W   = CNT_W - 11;

    sel_reg_t          sel_q;
    logic              load_en, clr_en, in_commit;
    logic [CNT_W-1:0]  sel_val, sel_word;
    logic              rd_take;

    stat_cnt_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (CNT_W),
        .NUM_CNT(NUM_CNT),
        .WIN_OFS(WIN_OFS),
        .SEL_OFS(SEL_OFS)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_ready(bus_ready),
        .sel_q    (sel_q),
        .load_en  (load_en),
        .clr_en   (clr_en),
        .in_commit(in_commit)
    );

    stat_cnt_bank #(
        .NUM_CNT(NUM_CNT),
        .CNT_W  (CNT_W)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     ({rx_evt, tx_evt}),
        .sel     (sel_q.idx),
        .load_en (load_en),
        .load_val(bus_wdata),
        .clr_en  (clr_en),
        .sel_val (sel_val)
    );

    assign sel_word = {{PAD_W{1'b0}}, sel_q.adv, sel_q.clr_rd, sel_q.wr_mode,
                       2'b00, sel_q.idx};
    assign rd_take  = bus_valid && bus_ready && !bus_write;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_take;
            if (rd_take) begin
                if (bus_addr == WIN_OFS)      bus_rdata <= sel_val;
                else if (bus_addr == SEL_OFS) bus_rdata <= sel_word;
                else                          bus_rdata <= '0;
            end
        end
    end

endmodule

// File: rtl/stat_cnt_window_chk.sv
module stat_cnt_window_chk #(
    parameter int ADDR_W  = 9,
    parameter int CNT_W   = 32,
    parameter int NUM_CNT = 38,
    parameter logic [ADDR_W-1:0] WIN_OFS = 9'h164,
    parameter logic [ADDR_W-1:0] SEL_OFS = 9'h168
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic              bus_rvalid,
    input logic [5:0]        idx,
    input logic              adv,
    input logic              in_commit
);

    logic win_take, rd_take;
    assign win_take = bus_valid && bus_ready && (bus_addr == WIN_OFS);
    assign rd_take  = bus_valid && bus_ready && !bus_write;

    p_busy_after_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_take |=> !bus_ready);

    p_busy_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> bus_ready);

    p_sel_no_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_addr == SEL_OFS) |=> bus_ready);

    p_read_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> bus_rvalid);

    p_no_spurious_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_take |=> !bus_rvalid);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && bus_addr == SEL_OFS) |=> (bus_rdata[31:11] == '0 && bus_rdata[7:6] == 2'b00));

    p_oob_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && bus_addr == WIN_OFS && idx >= 6'(NUM_CNT)) |=> bus_rdata == '0);

    p_advance_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_commit && adv) |=>
            idx == (($past(idx) >= 6'(NUM_CNT - 1)) ? 6'd0 : $past(idx) + 6'd1));

endmodule

bind stat_cnt_window stat_cnt_window_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .NUM_CNT(TX_CNT + RX_CNT),
    .WIN_OFS(WIN_OFS),
    .SEL_OFS(SEL_OFS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .idx       (sel_q.idx),
    .adv       (sel_q.adv),
    .in_commit (in_commit)
);

// File: tb/stat_cnt_window_tb_top.sv
module stat_cnt_window_tb_top;

    localparam int N = 38;
    localparam logic [8:0] WIN = 9'h164;
    localparam logic [8:0] SEL = 9'h168;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write;
    logic [8:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_ready, bus_rvalid;
    logic [N-1:0] evt;
    logic [31:0] exp_cnt [N];
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    stat_cnt_window dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .tx_evt(evt[14:0]), .rx_evt(evt[37:15])
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        if (a == WIN) begin
            chk(bus_ready == 1'b0, "R9 busy after window write", 32'(bus_ready), 32'd0);
            @(negedge clk);
        end
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        chk(bus_rvalid == 1'b1, "R4 read answer strobe", 32'(bus_rvalid), 32'd1);
        if (a == WIN) @(negedge clk);
    endtask

    task automatic pulse(input int i, input int n);
        @(negedge clk);
        evt[i] = 1'b1;
        repeat (n) @(negedge clk);
        evt = '0;
        exp_cnt[i] = exp_cnt[i] + 32'(n);
    endtask

    // read all counters from index 0 with auto-advance, optionally clearing
    task automatic sweep(input bit clear, input string tag);
        logic [31:0] d;
        bus_wr(SEL, clear ? 32'h600 : 32'h400);
        for (int i = 0; i < N; i++) begin
            bus_rd(WIN, d);
            chk(d == exp_cnt[i], tag, d, exp_cnt[i]);
            if (clear) exp_cnt[i] = '0;
        end
        bus_rd(SEL, d);
        chk(d[5:0] == 6'd0, "R7 index wrapped after sweep", d, 32'd0);
    endtask

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0; evt = '0;
        for (int i = 0; i < N; i++) exp_cnt[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(bus_ready == 1'b1, "R1 ready after reset", 32'(bus_ready), 32'd1);
        bus_rd(SEL, d);
        chk(d == 32'h0, "R1 selector after reset", d, 32'h0);
        sweep(1'b0, "R1 counter zero after reset");

        // R2 field layout and reserved bits
        bus_wr(SEL, 32'hFFFF_FFFF);
        bus_rd(SEL, d);
        chk(d == 32'h0000_073F, "R2 reserved bits read zero", d, 32'h0000_073F);
        bus_wr(SEL, 32'h0000_0405);
        chk(bus_ready == 1'b1, "R2 selector write keeps ready", 32'(bus_ready), 32'd1);
        bus_rd(SEL, d);
        bus_rd(SEL, d);
        chk(d == 32'h0000_0405, "R2 selector access does not advance", d, 32'h405);

        // R3 every strobe maps to its counter; R7 sweep with auto-advance
        for (int i = 0; i < N; i++) pulse(i, i + 1);
        sweep(1'b0, "R3 counter value after strobes");
        // R6 clear-after-read sweep then verify zero
        sweep(1'b1, "R6 value returned before clear");
        sweep(1'b0, "R6 counter zero after clearing read");

        // R6 strobe in the commit cycle of a clearing read
        pulse(3, 2);
        bus_wr(SEL, 32'h0000_0203);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = WIN;
        @(negedge clk);
        bus_valid = 1'b0; evt[3] = 1'b1;
        chk(bus_rdata == 32'd2, "R6 pre-clear value", bus_rdata, 32'd2);
        @(negedge clk);
        evt = '0;
        bus_rd(WIN, d);
        chk(d == 32'd1, "R6 strobe during clear survives", d, 32'd1);
        bus_rd(WIN, d);
        chk(d == 32'd0, "R6 cleared again", d, 32'd0);
        exp_cnt[3] = '0;
        bus_rd(SEL, d);
        chk(d == 32'h203, "R7 no advance when disabled", d, 32'h203);

        // R5 load and R3 wrap
        bus_wr(SEL, 32'h0000_0107);
        bus_wr(WIN, 32'hFFFF_FFFE);
        exp_cnt[7] = 32'hFFFF_FFFE;
        pulse(7, 2);
        bus_wr(SEL, 32'h0000_0007);
        bus_rd(WIN, d);
        chk(d == 32'h0, "R3 wrap past all ones", d, 32'h0);
        // R5 load overrides a coincident strobe
        bus_wr(SEL, 32'h0000_0107);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = WIN; bus_wdata = 32'h1234_5678; evt[7] = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; evt = '0;
        @(negedge clk);
        exp_cnt[7] = 32'h1234_5678;
        // R5 write in read mode is ignored
        bus_wr(SEL, 32'h0000_0007);
        bus_wr(WIN, 32'h0000_DEAD);
        bus_rd(WIN, d);
        chk(d == 32'h1234_5678, "R5 load exact and read-mode write ignored", d, 32'h1234_5678);
        // R7 advance on write, wrapping from last index
        bus_wr(SEL, 32'h0000_0525);
        bus_wr(WIN, 32'h0000_00AA);
        exp_cnt[37] = 32'hAA;
        bus_rd(SEL, d);
        chk(d == 32'h500, "R7 write advances and wraps", d, 32'h500);

        // R8 out-of-range index
        bus_wr(SEL, 32'h0000_0130);
        bus_wr(WIN, 32'h0000_0055);
        bus_wr(SEL, 32'h0000_0430);
        bus_rd(WIN, d);
        chk(d == 32'h0, "R8 out-of-range read is zero", d, 32'h0);
        bus_rd(SEL, d);
        chk(d == 32'h400, "R7 wrap from out-of-range index", d, 32'h400);

        // R4 unmapped offset
        bus_rd(9'h100, d);
        chk(d == 32'h0, "R4 unmapped offset reads zero", d, 32'h0);

        // R9 access offered while busy is dropped
        bus_wr(SEL, 32'h0000_0011);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = WIN;
        @(negedge clk);
        bus_write = 1'b1; bus_addr = SEL; bus_wdata = 32'h0000_0000;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_rd(SEL, d);
        chk(d == 32'h11, "R9 access during busy cycle ignored", d, 32'h11);

        // R8 final sweep: no counter touched by out-of-range write
        sweep(1'b0, "R8 bank unchanged by out-of-range write");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule